// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Analog and Reset-Pin Options

This block is a small memory-mapped I/O port with four pins. Three of them are bidirectional. Each has a direction bit and an output-latch bit, and a configuration input can switch each one into analog mode. While a pin is in analog mode, its digital read value is forced to zero. The fourth pin is input-only. A configuration bit decides what it does: it is either a plain digital input or the device's active-low master-clear reset input.

Software reaches the port through a simple register bus. Writes are synchronous and reads are combinational. There are three registers: a pin-read register, an output-latch register and a direction register. The upper part of the direction register is only stored and exported as control bits for a neighbouring parallel-port block. Digital pin levels pass through a two-flop synchronizer before they can be read. A build parameter can remove the port altogether; in that case every read returns zero.

Top module: `gpio_quad_port`

## Requirements
- R1: A direction bit at 0 enables the driver of its bidirectional pin (`pad_oe` bit = 1) and drives the latch value. A direction bit at 1 puts the pin in high impedance (`pad_oe` bit = 0). A write to address 2 takes effect at the next clock edge.
- R2: A read at address 1 returns the stored latch value in bits 2:0, with zeros above, whatever the pin levels are.
- R3: A write to address 0 loads the output latch exactly as a write to address 1 does, from write-data bits 2:0.
- R4: A pin whose `cfg_analog` bit is 1 reads as 0 at address 0. Its direction bit still controls `pad_oe`.
- R5: Pin 3 has no direction or latch bit. Direction bit 3 and latch-read bits 7:3 always read 0. With `cfg_mclr_en` = 0, pin 3 reads at address 0 bit 3 and `mclr_n` stays 1.
- R6: With `cfg_mclr_en` = 1, `mclr_n` follows `pad_in[3]` combinationally and address 0 bit 3 reads 0.
- R7: Direction bits 7:4 are stored, read back at address 2 and driven on `psp_ctrl`, with no other effect.
- R8: A pin level change shows at address 0 after the second rising clock edge, and not after the first.
- R9: Reset sets the latch to 0 and the direction register to 0xF7 (all implemented bits 1), so no pin is driven.
- R10: With `PORT_PRESENT` = 0, every read returns 0x00, `pad_oe` stays 0 and writes have no visible effect.
- R11: Address 3 reads 0x00, and a write to it changes no register.
- R12: Address 0 bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin read / latch write, 1 latch, 2 direction, 3 unused |
| bus_wr_en | input | 1 | Write strobe, sampled on rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cfg_analog | input | 3 | Per-pin analog-mode select, 1 = analog |
| cfg_mclr_en | input | 1 | 1 = pin 3 is master-clear, 0 = digital input |
| pad_in | input | 4 | Pin levels from the pads |
| pad_out | output | 3 | Output-latch values to the pads |
| pad_oe | output | 3 | Driver enables, 1 = drive |
| mclr_n | output | 1 | Active-low master-clear request |
| psp_ctrl | output | 4 | Stored upper direction bits |

## Verification
The bench looks at the synchronizer latency on the exact cycle. A design with one stage too few would show the new level one cycle early, and one with an extra stage would show it one cycle late. It sets analog mode and the direction bits in different combinations. A design that let analog mode gate the driver would wrongly tri-state a pin. It drives pins against the latch to catch a latch read that returns the pin level instead. It checks that pin 3 is muxed into the read path or the reset output as configured. It checks that the unused address and the removed-port variant leave the registers unchanged. Random writes and pin patterns are compared against a bench model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_ADDR_W = 2;

  typedef enum logic [BUS_ADDR_W-1:0] {
    SEL_PINS  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q, stage2_q;
  logic [WIDTH-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = async_in;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_BIDIR = 3,
  parameter int DATA_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_BIDIR-1:0]  lat_q,
  output logic [DATA_W-1:0]     dir_q
);
  localparam logic [DATA_W-1:0] DIR_MASK  = ~(DATA_W'(1) << NUM_BIDIR);
  localparam logic [DATA_W-1:0] DIR_RESET = DIR_MASK;

  logic [NUM_BIDIR-1:0] lat_d;
  logic [DATA_W-1:0]    dir_d;
  logic                 lat_load, dir_load;

  always_comb begin
    lat_load = wr_en && ((addr == SEL_PINS) || (addr == SEL_LATCH));
    dir_load = wr_en && (addr == SEL_DIR);
    lat_d    = lat_q;
    dir_d    = dir_q;
    if (lat_load) lat_d = wdata[NUM_BIDIR-1:0];
    if (dir_load) dir_d = wdata & DIR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= DIR_RESET;
    end else begin
      if (lat_load) lat_q <= lat_d;
      if (dir_load) dir_q <= dir_d;
    end
  end

  // R3: both the pin-read address and the latch address load the latch
  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == SEL_PINS || addr == SEL_LATCH)) |=> lat_q == $past(wdata[NUM_BIDIR-1:0]));
  // R11: the spare address and idle cycles leave the registers alone
  assert_spare_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr == SEL_SPARE) |=> ($stable(lat_q) && $stable(dir_q)));
  // R5: direction bit of the input-only pin never becomes 1
  assert_dir_bit3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q[NUM_BIDIR]);
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int NUM_BIDIR = 3,
  parameter int DATA_W    = 8
) (
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [NUM_BIDIR:0]    pins_sync,
  input  logic [NUM_BIDIR-1:0]  analog_sel,
  input  logic                  mclr_en,
  input  logic [NUM_BIDIR-1:0]  lat_q,
  input  logic [DATA_W-1:0]     dir_q,
  output logic [DATA_W-1:0]     rdata
);
  localparam int NUM_PINS = NUM_BIDIR + 1;

  logic [NUM_PINS-1:0] pin_view;

  for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_bidir_view
    assign pin_view[i] = pins_sync[i] & ~analog_sel[i];
  end
  assign pin_view[NUM_BIDIR] = pins_sync[NUM_BIDIR] & ~mclr_en;

  always_comb begin
    rdata = '0;
    unique case (addr)
      SEL_PINS:  rdata = {{(DATA_W-NUM_PINS){1'b0}}, pin_view};
      SEL_LATCH: rdata = {{(DATA_W-NUM_BIDIR){1'b0}}, lat_q};
      SEL_DIR:   rdata = dir_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_BIDIR    = 3,
  parameter int DATA_W       = 8,
  parameter bit PORT_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr_en,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [2:0]  cfg_analog,
  input  logic        cfg_mclr_en,
  input  logic [3:0]  pad_in,
  output logic [2:0]  pad_out,
  output logic [2:0]  pad_oe,
  output logic        mclr_n,
  output logic [3:0]  psp_ctrl
);
  localparam int NUM_PINS = NUM_BIDIR + 1;
  localparam int PSP_W    = DATA_W - NUM_PINS;

  // reset-pin mux stays alive in every variant
  assign mclr_n = cfg_mclr_en ? pad_in[NUM_BIDIR] : 1'b1;

  if (PORT_PRESENT) begin : g_port
    logic [NUM_PINS-1:0]  pins_sync;
    logic [NUM_BIDIR-1:0] lat_q;
    logic [DATA_W-1:0]    dir_q;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pins_sync)
    );

    gpio_regs #(.NUM_BIDIR(NUM_BIDIR), .DATA_W(DATA_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr_en),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .lat_q (lat_q),
      .dir_q (dir_q)
    );

    gpio_read_mux #(.NUM_BIDIR(NUM_BIDIR), .DATA_W(DATA_W)) u_rmux (
      .addr       (bus_addr),
      .pins_sync  (pins_sync),
      .analog_sel (cfg_analog),
      .mclr_en    (cfg_mclr_en),
      .lat_q      (lat_q),
      .dir_q      (dir_q),
      .rdata      (bus_rdata)
    );

    assign pad_out  = lat_q;
    assign pad_oe   = ~dir_q[NUM_BIDIR-1:0];
    assign psp_ctrl = dir_q[DATA_W-1 -: PSP_W];

    // R1: a direction write shows on the driver enables one edge later
    assert_oe_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == SEL_DIR) |=> pad_oe == ~$past(bus_wdata[NUM_BIDIR-1:0]));
    // R2: latch read equals what is driven toward the pads
    assert_latch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_LATCH) |-> bus_rdata == {{(DATA_W-NUM_BIDIR){1'b0}}, pad_out});
    // R4: analog pins never read 1 on the pin-read path
    assert_analog_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_PINS) |-> (bus_rdata[NUM_BIDIR-1:0] & cfg_analog) == '0);
    // R6: pin 3 reads 0 while it serves as master-clear
    assert_mclr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_PINS && cfg_mclr_en) |-> !bus_rdata[NUM_BIDIR]);
    // R7: a direction write shows on the exported control bits one edge later
    assert_psp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == SEL_DIR) |=> psp_ctrl == $past(bus_wdata[DATA_W-1 -: PSP_W]));
  end else begin : g_absent
    assign bus_rdata = '0;
    assign pad_out   = '0;
    assign pad_oe    = '0;
    assign psp_ctrl  = '0;
  end
endmodule

// File: tb/tb_gpio_quad_port.sv
module tb_gpio_quad_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr_en;
  logic [7:0] bus_wdata;
  logic [2:0] cfg_analog;
  logic       cfg_mclr_en;
  logic [3:0] pad_in;
  logic [7:0] rdata, rdata_l;
  logic [2:0] pad_out, pad_oe, pad_out_l, pad_oe_l;
  logic       mclr_n, mclr_n_l;
  logic [3:0] psp_ctrl, psp_ctrl_l;

  int total = 0;
  int fails = 0;
  logic [2:0] m_lat;
  logic [7:0] m_dir;

  always #10 clk = ~clk;

  gpio_quad_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .cfg_analog(cfg_analog),
    .cfg_mclr_en(cfg_mclr_en), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .mclr_n(mclr_n), .psp_ctrl(psp_ctrl));

  gpio_quad_port #(.PORT_PRESENT(1'b0)) dut_lite (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .cfg_analog(cfg_analog),
    .cfg_mclr_en(cfg_mclr_en), .pad_in(pad_in), .pad_out(pad_out_l),
    .pad_oe(pad_oe_l), .mclr_n(mclr_n_l), .psp_ctrl(psp_ctrl_l));

  function automatic logic [7:0] exp_pins(logic [3:0] pads, logic [2:0] an, logic mc);
    return {4'b0, pads[3] & ~mc, pads[2:0] & ~an};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a == 2'd0 || a == 2'd1) m_lat = d[2:0];
    if (a == 2'd2) m_dir = d & 8'hF7;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = rdata;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0;
    cfg_analog = '0; cfg_mclr_en = 1'b0; pad_in = '0;
    m_lat = '0; m_dir = 8'hF7;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R9 reset state
    rd(2'd1, v); chk("R9 latch reset", v, 8'h00);
    rd(2'd2, v); chk("R9 dir reset", v, 8'hF7);
    chk("R9 oe reset", {5'b0, pad_oe}, 8'h00);
    chk("R7 psp reset", {4'b0, psp_ctrl}, 8'h0F);

    // R1 direction drives enables
    bus_write(2'd2, 8'h52);
    chk("R1 oe", {5'b0, pad_oe}, 8'h05);
    chk("R7 psp", {4'b0, psp_ctrl}, 8'h05);
    rd(2'd2, v); chk("R5 dir bit3 / R7 readback", v, 8'h52);
    bus_write(2'd2, 8'hAF);
    rd(2'd2, v); chk("R5 dir bit3 masked", v, 8'hA7);

    // R2 latch read vs pins
    bus_write(2'd1, 8'hFD);
    pad_in = 4'hA;
    settle(3);
    rd(2'd1, v); chk("R2 latch read", v, 8'h05);
    rd(2'd0, v); chk("R5 pins read", v, 8'h0A);
    chk("R5 mclr idle", {7'b0, mclr_n}, 8'h01);

    // R3 pin-address write loads latch
    bus_write(2'd0, 8'h03);
    rd(2'd1, v); chk("R3 latch via pin addr", v, 8'h03);
    chk("R3 pad_out", {5'b0, pad_out}, 8'h03);

    // R8 synchronizer latency
    pad_in = 4'h0; settle(3);
    pad_in = 4'hF;
    @(negedge clk); rd(2'd0, v); chk("R8 after one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R8 after two edges", v, 8'h0F);
    rd(2'd0, v); chk("R12 upper bits zero", v & 8'hF0, 8'h00);

    // R4 analog masking, direction still effective
    cfg_analog = 3'b101; #1;
    rd(2'd0, v); chk("R4 analog read", v, 8'h0A);
    bus_write(2'd2, 8'h00);
    chk("R4 oe in analog", {5'b0, pad_oe}, 8'h07);

    // R6 master-clear
    cfg_mclr_en = 1'b1; pad_in = 4'hF; #1;
    rd(2'd0, v); chk("R6 pin3 reads 0", v & 8'h08, 8'h00);
    chk("R6 mclr high", {7'b0, mclr_n}, 8'h01);
    pad_in = 4'h7; #1;
    chk("R6 mclr follows", {7'b0, mclr_n}, 8'h00);
    cfg_mclr_en = 1'b0; #1;
    chk("R5 mclr off", {7'b0, mclr_n}, 8'h01);

    // R11 spare address
    bus_write(2'd3, 8'hFF);
    rd(2'd3, v); chk("R11 spare read", v, 8'h00);
    rd(2'd1, v); chk("R11 latch kept", v, {5'b0, m_lat});
    rd(2'd2, v); chk("R11 dir kept", v, m_dir);

    // R10 absent variant
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h07);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      chk("R10 lite read", rdata_l, 8'h00);
    end
    chk("R10 lite oe", {5'b0, pad_oe_l}, 8'h00);

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      pad_in = 4'($urandom); cfg_analog = 3'($urandom); cfg_mclr_en = 1'($urandom);
      bus_write(a, 8'($urandom));
      settle(2);
      rd(2'd0, v); chk("R4 R6 R8 random pins", v, exp_pins(pad_in, cfg_analog, cfg_mclr_en));
      rd(2'd1, v); chk("R2 R3 random latch", v, {5'b0, m_lat});
      rd(2'd2, v); chk("R1 R7 random dir", v, m_dir);
      chk("R1 random oe", {5'b0, pad_oe}, {5'b0, ~m_dir[2:0]});
      chk("R6 random mclr", {7'b0, mclr_n}, {7'b0, cfg_mclr_en ? pad_in[3] : 1'b1});
      rd(2'd0, v); chk("R10 random lite", rdata_l, 8'h00);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule